// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

A synchronous true dual-port RAM with two symmetric ports, called left and right. Each port can read or write any word on any clock edge, independently of the other. The two highest addresses double as doorbells between the two sides:

- Address `2^ADDR_W - 2` is the left side's mailbox.
- Address `2^ADDR_W - 1` is the right side's mailbox.

When one side writes into the other side's mailbox, the receiving side's sticky interrupt flag goes up. The flag stays up until the receiving side reads its own mailbox word. The message itself is ordinary RAM data at that address.

Each port has a chip select, an output enable, a write strobe, an address, write data, registered read data and an active-low interrupt output driven both ways. All control inputs are active high. Reset is synchronous and active high.

The default parameters give 2048 words of 8 bits. Setting `ADDR_W = 13` gives the 8192 × 8 organisation, with mailboxes at 0x1FFE (left) and 0x1FFF (right).

Top module: `mbox_dpram`

## Requirements
- R1: A read is `cs && oe && !wr` on a port. It returns the word at its address on that port's `rdata`, which is valid from the clock edge that accepts the read. A word written on one edge is returned by a read on the same port issued at any later edge.
- R2: A word written by one port is returned to the other port by any read issued at a later edge. A read of the same address issued at the same edge as the other port's write returns the old word.
- R3: Without a read on a port (`cs` low, `oe` low or `wr` high), that port's `rdata` keeps its value. A write needs `cs && wr`, so `wr` with `cs` low stores nothing.
- R4: A right-port write to address `2^ADDR_W - 2` drives `l_irq_n` low from the next edge.
- R5: A left-port read of address `2^ADDR_W - 2` drives `l_irq_n` high from the next edge, unless R8 applies.
- R6: A left-port write to address `2^ADDR_W - 1` drives `r_irq_n` low from the next edge.
- R7: A right-port read of address `2^ADDR_W - 1` drives `r_irq_n` high from the next edge, unless R8 applies.
- R8: When a flag is set and cleared on the same edge, it ends up set (interrupt output low).
- R9: During reset both interrupt outputs are high and both `rdata` outputs are 0.
- R10: No other access changes a flag. This includes:
  - a port writing its own mailbox;
  - a port reading the other side's mailbox;
  - a mailbox access without `oe`.

  Mailbox words read and write like any other RAM word.
- R11: When both ports write the same address on the same edge, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_cs | input | 1 | Left chip select |
| l_oe | input | 1 | Left output enable, needed for a read |
| l_wr | input | 1 | Left write strobe |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs | input | 1 | Right chip select |
| r_oe | input | 1 | Right output enable, needed for a read |
| r_wr | input | 1 | Right write strobe |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with `ADDR_W = 6` and `DATA_W = 8`. This gives a 64-word array with its mailboxes at 62 and 63, so every word can be written from one side and read back from the other, in both directions.

That small depth puts the mailbox words inside the full sweeps. It also makes the flag corners cheap to reach:
- set and clear on the same edge;
- a write to a port's own mailbox;
- a read without `oe`;
- a same-edge write collision.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int NUM_PORTS = 2;

    // Decoded access of one port for one cycle
    typedef struct packed {
        logic rd;       // plain read (cs, oe, not wr)
        logic wr;       // plain write (cs, wr)
        logic rd_own;   // read of this port's own mailbox word
        logic wr_peer;  // write into the other port's mailbox word
    } port_acc_t;

    // Register state of one doorbell flag
    typedef struct packed {
        logic pend;
    } flag_st_t;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '0,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  logic              cs,
    input  logic              oe,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output port_acc_t         acc
);

    logic rd_hit;
    logic wr_hit;

    always_comb begin
        rd_hit      = cs & oe & ~wr;
        wr_hit      = cs & wr;
        acc         = '0;
        acc.rd      = rd_hit;
        acc.wr      = wr_hit;
        acc.rd_own  = rd_hit & (addr == OWN_BOX);
        acc.wr_peer = wr_hit & (addr == PEER_BOX);
    end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    flag_st_t st_d;
    flag_st_t st_q;

    // Set has priority over clear on the same edge
    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.pend = 1'b1;
        end else if (clr) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = ~st_q.pend;

endmodule

// File: rtl/mbox_mem.sv
module mbox_mem
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_PORTS-1:0]                we,
    input  logic [NUM_PORTS-1:0]                re,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]    wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]    rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0]                   mem_q [DEPTH];
    logic [NUM_PORTS-1:0][DATA_W-1:0]    rdata_d;
    logic [NUM_PORTS-1:0][DATA_W-1:0]    rdata_q;

    // Read capture: old contents are seen by a read on the writing edge
    always_comb begin
        rdata_d = rdata_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (re[p]) begin
                rdata_d[p] = mem_q[addr[p]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    // Array update: port 0 is applied last, so it wins a same-address collision
    always_ff @(posedge clk) begin
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (we[p]) begin
                mem_q[addr[p]] <= wdata[p];
            end
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cs,
    input  logic              l_oe,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_cs,
    input  logic              r_oe,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);

    // Mailbox words at the top of the array: index 0 is left, index 1 is right
    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

    logic      [NUM_PORTS-1:0]              cs_v;
    logic      [NUM_PORTS-1:0]              oe_v;
    logic      [NUM_PORTS-1:0]              wr_v;
    logic      [NUM_PORTS-1:0][ADDR_W-1:0]  addr_v;
    logic      [NUM_PORTS-1:0][DATA_W-1:0]  wdata_v;
    logic      [NUM_PORTS-1:0][DATA_W-1:0]  rdata_v;
    logic      [NUM_PORTS-1:0]              we_v;
    logic      [NUM_PORTS-1:0]              re_v;
    logic      [NUM_PORTS-1:0]              irq_n_v;
    port_acc_t [NUM_PORTS-1:0]              acc_v;

    assign cs_v    = {r_cs, l_cs};
    assign oe_v    = {r_oe, l_oe};
    assign wr_v    = {r_wr, l_wr};
    assign addr_v  = {r_addr, l_addr};
    assign wdata_v = {r_wdata, l_wdata};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? BOX_L : BOX_R;
        localparam logic [ADDR_W-1:0] PEER = (p == 0) ? BOX_R : BOX_L;

        mbox_port_dec #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_dec (
            .cs   (cs_v[p]),
            .oe   (oe_v[p]),
            .wr   (wr_v[p]),
            .addr (addr_v[p]),
            .acc  (acc_v[p])
        );

        // Raised by the other port's write into this mailbox, dropped by own read
        mbox_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set   (acc_v[NUM_PORTS-1-p].wr_peer),
            .clr   (acc_v[p].rd_own),
            .irq_n (irq_n_v[p])
        );

        assign we_v[p] = acc_v[p].wr;
        assign re_v[p] = acc_v[p].rd;
    end

    mbox_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (we_v),
        .re    (re_v),
        .addr  (addr_v),
        .wdata (wdata_v),
        .rdata (rdata_v)
    );

    assign l_rdata = rdata_v[0];
    assign r_rdata = rdata_v[1];
    assign l_irq_n = irq_n_v[0];
    assign r_irq_n = irq_n_v[1];

endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              l_cs,
    input logic              l_oe,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_wdata,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic              r_cs,
    input logic              r_oe,
    input logic              r_wr,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_wdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

    logic ring_l;
    logic ring_r;
    logic ack_l;
    logic ack_r;
    logic rd_l;
    logic rd_r;

    assign rd_l   = l_cs && l_oe && !l_wr;
    assign rd_r   = r_cs && r_oe && !r_wr;
    assign ring_l = r_cs && r_wr && (r_addr == BOX_L);
    assign ring_r = l_cs && l_wr && (l_addr == BOX_R);
    assign ack_l  = rd_l && (l_addr == BOX_L);
    assign ack_r  = rd_r && (r_addr == BOX_R);

    // R4 and R8: the set wins whether or not a clear comes with it
    a_r4_left_set: assert property (@(posedge clk) disable iff (rst)
        ring_l |=> !l_irq_n);

    // R6 and R8
    a_r6_right_set: assert property (@(posedge clk) disable iff (rst)
        ring_r |=> !r_irq_n);

    // R5
    a_r5_left_clear: assert property (@(posedge clk) disable iff (rst)
        (ack_l && !ring_l) |=> l_irq_n);

    // R7
    a_r7_right_clear: assert property (@(posedge clk) disable iff (rst)
        (ack_r && !ring_r) |=> r_irq_n);

    // R10: left flag moves only on its own set or clear events
    a_r10_left_hold: assert property (@(posedge clk) disable iff (rst)
        (!ring_l && !ack_l) |=> $stable(l_irq_n));

    // R10: right flag moves only on its own set or clear events
    a_r10_right_hold: assert property (@(posedge clk) disable iff (rst)
        (!ring_r && !ack_r) |=> $stable(r_irq_n));

    // R3: left read data holds when the port issues no read
    a_r3_left_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_l |=> $stable(l_rdata));

    // R3: right read data holds when the port issues no read
    a_r3_right_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_r |=> $stable(r_rdata));

endmodule

bind mbox_dpram mbox_dpram_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/mbox_dpram_tb.sv
module mbox_dpram_tb;

    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] BOX_L = AW'(DEPTH - 2);
    localparam logic [AW-1:0] BOX_R = AW'(DEPTH - 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          l_cs, l_oe, l_wr, r_cs, r_oe, r_wr;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_irq_n, r_irq_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mbox_dpram #(
        .ADDR_W (AW),
        .DATA_W (DW)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .l_cs    (l_cs),
        .l_oe    (l_oe),
        .l_wr    (l_wr),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .l_irq_n (l_irq_n),
        .r_cs    (r_cs),
        .r_oe    (r_oe),
        .r_wr    (r_wr),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata),
        .r_irq_n (r_irq_n)
    );

    function automatic logic [DW-1:0] pat(input int a, input int seed);
        return DW'(a * 29 + seed * 71 + 5);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Applies one cycle of stimulus on both ports, returns after the next negedge
    task automatic drive(input logic lc, input logic lo, input logic lw,
                         input logic [AW-1:0] la, input logic [DW-1:0] ld,
                         input logic rc, input logic ro, input logic rw,
                         input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        l_cs = lc; l_oe = lo; l_wr = lw; l_addr = la; l_wdata = ld;
        r_cs = rc; r_oe = ro; r_wr = rw; r_addr = ra; r_wdata = rd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        l_cs = 0; l_oe = 0; l_wr = 0; l_addr = '0; l_wdata = '0;
        r_cs = 0; r_oe = 0; r_wr = 0; r_addr = '0; r_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9 l_irq_n", {7'd0, l_irq_n}, 8'd1);
        check("R9 r_irq_n", {7'd0, r_irq_n}, 8'd1);
        check("R9 l_rdata", l_rdata, 8'd0);
        check("R9 r_rdata", r_rdata, 8'd0);
        rst = 1'b0;

        // Left fills every word, right reads each back (R2)
        for (int a = 0; a < DEPTH; a++)
            drive(1, 0, 1, AW'(a), pat(a, 1), 0, 0, 0, '0, '0);
        check("R6 r_irq_n after left fill", {7'd0, r_irq_n}, 8'd0);
        check("R10 l_irq_n after left fill", {7'd0, l_irq_n}, 8'd1);
        for (int a = 0; a < DEPTH; a++) begin
            drive(0, 0, 0, '0, '0, 1, 1, 0, AW'(a), '0);
            check("R2 right reads left data", r_rdata, pat(a, 1));
            if (a == int'(BOX_L))
                check("R10 right read of left box", {7'd0, l_irq_n}, 8'd1);
        end
        check("R7 r_irq_n after right sweep", {7'd0, r_irq_n}, 8'd1);

        // Right fills every word, left reads each back (R2)
        for (int a = 0; a < DEPTH; a++)
            drive(0, 0, 0, '0, '0, 1, 0, 1, AW'(a), pat(a, 2));
        check("R4 l_irq_n after right fill", {7'd0, l_irq_n}, 8'd0);
        check("R10 r_irq_n after right fill", {7'd0, r_irq_n}, 8'd1);
        for (int a = 0; a < DEPTH; a++) begin
            drive(1, 1, 0, AW'(a), '0, 0, 0, 0, '0, '0);
            check("R2 left reads right data", l_rdata, pat(a, 2));
        end
        check("R5 l_irq_n after left sweep", {7'd0, l_irq_n}, 8'd1);

        // R1 same-port write then read
        drive(1, 0, 1, AW'(5), 8'hA5, 0, 0, 0, '0, '0);
        drive(1, 1, 0, AW'(5), '0, 0, 0, 0, '0, '0);
        check("R1 left read after write", l_rdata, 8'hA5);
        drive(0, 0, 0, '0, '0, 1, 0, 1, AW'(7), 8'h7E);
        drive(0, 0, 0, '0, '0, 1, 1, 0, AW'(7), '0);
        check("R1 right read after write", r_rdata, 8'h7E);

        // R2 same-edge write/read returns old word, next read the new one
        drive(1, 0, 1, AW'(10), 8'h3C, 1, 1, 0, AW'(10), '0);
        check("R2 same-edge old data", r_rdata, pat(10, 2));
        drive(0, 0, 0, '0, '0, 1, 1, 0, AW'(10), '0);
        check("R2 next read new data", r_rdata, 8'h3C);

        // R3 hold and write gating
        drive(1, 0, 0, AW'(10), '0, 0, 0, 0, '0, '0);
        check("R3 oe low holds rdata", l_rdata, 8'hA5);
        drive(0, 1, 0, AW'(10), '0, 0, 0, 0, '0, '0);
        check("R3 cs low holds rdata", l_rdata, 8'hA5);
        drive(0, 0, 1, AW'(10), 8'hFF, 0, 0, 0, '0, '0);
        drive(1, 1, 0, AW'(10), '0, 0, 0, 0, '0, '0);
        check("R3 write without cs ignored", l_rdata, 8'h3C);

        // R8 set beats clear on the same edge, both sides
        drive(1, 1, 0, BOX_L, '0, 1, 0, 1, BOX_L, 8'h11);
        check("R8 left set wins", {7'd0, l_irq_n}, 8'd0);
        drive(1, 0, 1, BOX_R, 8'h22, 1, 1, 0, BOX_R, '0);
        check("R8 right set wins", {7'd0, r_irq_n}, 8'd0);

        // R10 non-clearing mailbox accesses
        drive(1, 0, 1, BOX_L, 8'h44, 0, 0, 0, '0, '0);
        check("R10 own box write keeps flag", {7'd0, l_irq_n}, 8'd0);
        drive(0, 0, 0, '0, '0, 1, 1, 0, BOX_L, '0);
        check("R10 box data is ram", r_rdata, 8'h44);
        check("R10 peer read keeps flag", {7'd0, l_irq_n}, 8'd0);
        drive(1, 0, 0, BOX_L, '0, 0, 0, 0, '0, '0);
        check("R10 read without oe keeps flag", {7'd0, l_irq_n}, 8'd0);
        drive(0, 0, 0, '0, '0, 1, 0, 1, BOX_R, 8'h99);
        check("R10 right own box write keeps flag", {7'd0, r_irq_n}, 8'd0);
        drive(1, 1, 0, BOX_L, '0, 1, 1, 0, BOX_R, '0);
        check("R5 left clear", {7'd0, l_irq_n}, 8'd1);
        check("R7 right clear", {7'd0, r_irq_n}, 8'd1);
        check("R5 left box data", l_rdata, 8'h44);
        check("R7 right box data", r_rdata, 8'h99);

        // R11 same-address write collision
        drive(1, 0, 1, AW'(20), 8'h5A, 1, 0, 1, AW'(20), 8'hA5);
        drive(1, 1, 0, AW'(20), '0, 1, 1, 0, AW'(20), '0);
        check("R11 left wins left view", l_rdata, 8'h5A);
        check("R11 left wins right view", r_rdata, 8'h5A);

        drive(0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
        finish_run();
    end

endmodule